// File: doc/BRIEF.md
# Output Range Clamp

This block limits each colour component of a three-component pixel stream to a window chosen by a small format code. It sits at the end of a display output pipe, after the components have been brought to a common MSB-aligned width, and constrains the values to the legal code range of a limited-range signal. A single enable bit turns the whole function off.

The format code either leaves the data alone or picks a limited-range window. Three codes choose fixed windows for 8, 10 and 12 bits per channel. On the MSB-aligned 12-bit path these windows all land at 256..3760. A fourth code uses a separate programmable window for each component. The programmable bounds sit in registers that load on a strobe and come out of reset at lower 0x010 and upper 0xFEF. Each result is registered once, and the valid strobe travels alongside it.

Top module: `range_clamp`

## Requirements
- R1: While reset is asserted and after it is released, before any valid input is taken, `vld_o` is 0 and `pix_o` is 0.
- R2: With `en_i` low, a valid pixel reaches `pix_o` unchanged for every value of `fmt_i`.
- R3: With `en_i` high, format code 0 (full range) and the undefined codes 4, 5 and 6 pass the pixel through unchanged.
- R4: With `en_i` high, format codes 1, 2 and 3 (8, 10 and 12 bits per channel) limit every component to 256..3760 (0x100..0xEB0).
- R5: With `en_i` high, format code 7 limits each component to its programmable window. Until the first load after reset, that window is 0x010..0xFEF for every component.
- R6: A high `bnd_ld_i` at a rising edge stores `lo_i` and `hi_i` as the programmable bounds. A pixel taken on that same edge still uses the old bounds. Pixels taken on later edges use the new ones.
- R7: A component below the active lower bound outputs the lower bound. One above the upper bound outputs the upper bound. One inside the window passes unchanged. If the lower bound exceeds the upper bound, the lower-bound test is applied first.
- R8: `pix_o` and `vld_o` show the result of the input taken on the previous rising edge. `vld_o` equals the previous `vld_i`. `pix_o` holds its value when `vld_i` was low.
- R9: The component fields are R in bits [35:24], G in [23:12] and B in [11:0], for `pix_i`, `pix_o`, `lo_i` and `hi_i`. Each component is clamped against its own bounds, independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clamp enable |
| fmt_i | input | 3 | Format code: 0 full, 1/2/3 fixed window, 7 programmable |
| bnd_ld_i | input | 1 | Load strobe for the programmable bounds |
| lo_i | input | 36 | Lower bounds to load, R/G/B packed |
| hi_i | input | 36 | Upper bounds to load, R/G/B packed |
| pix_i | input | 36 | Input pixel, R/G/B packed |
| vld_i | input | 1 | Input pixel valid |
| pix_o | output | 36 | Clamped pixel, registered |
| vld_o | output | 1 | Output valid, one cycle after vld_i |

## Verification
The checker checks the following on every cycle:
- the valid strobe is delayed by exactly one cycle;
- the output is held when no pixel was taken;
- the output is a straight copy when the clamp is disabled or the format code is 0, 4, 5 or 6;
- every component stays inside 0x100..0xEB0 for the fixed-window codes.

Only the bench scenarios can show the behaviour that depends on the hidden bound registers. This covers the reset defaults of the programmable window, the rule that a load does not affect the pixel taken on the same edge, and the lower-first priority when the bounds are crossed.

// File: rtl/range_clamp_pkg.sv
package range_clamp_pkg;

  localparam logic [2:0] FMT_FULL  = 3'd0;
  localparam logic [2:0] FMT_LIM8  = 3'd1;
  localparam logic [2:0] FMT_LIM10 = 3'd2;
  localparam logic [2:0] FMT_LIM12 = 3'd3;
  localparam logic [2:0] FMT_PROG  = 3'd7;

  // limited-range code window at 'depth' bits, MSB-aligned onto 'cw' bits
  function automatic int win_lo(int cw, int depth);
    return (16 << (depth - 8)) << (cw - depth);
  endfunction

  function automatic int win_hi(int cw, int depth);
    return (235 << (depth - 8)) << (cw - depth);
  endfunction

endpackage

// File: rtl/clamp_bounds.sv
module clamp_bounds #(
  parameter int unsigned          CW     = 12,
  parameter int unsigned          NCH    = 3,
  parameter logic [CW-1:0]        LO_RST = 'h010,
  parameter logic [CW-1:0]        HI_RST = 'hFEF,
  localparam int unsigned         PW     = CW * NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [PW-1:0] lo_i,
  input  logic [PW-1:0] hi_i,
  output logic [PW-1:0] lo_q_o,
  output logic [PW-1:0] hi_q_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= LO_RST;
        hi_q <= HI_RST;
      end else if (ld_i) begin
        lo_q <= lo_i[c*CW +: CW];
        hi_q <= hi_i[c*CW +: CW];
      end
    end
    assign lo_q_o[c*CW +: CW] = lo_q;
    assign hi_q_o[c*CW +: CW] = hi_q;
  end

endmodule

// File: rtl/clamp_window_sel.sv
module clamp_window_sel
  import range_clamp_pkg::*;
#(
  parameter int unsigned  CW  = 12,
  parameter int unsigned  NCH = 3,
  localparam int unsigned PW  = CW * NCH
) (
  input  logic          en_i,
  input  logic [2:0]    fmt_i,
  input  logic [PW-1:0] prog_lo_i,
  input  logic [PW-1:0] prog_hi_i,
  output logic          act_o,
  output logic [PW-1:0] lo_o,
  output logic [PW-1:0] hi_o
);

  localparam logic [CW-1:0] LO8  = CW'(win_lo(CW, 8));
  localparam logic [CW-1:0] HI8  = CW'(win_hi(CW, 8));
  localparam logic [CW-1:0] LO10 = CW'(win_lo(CW, 10));
  localparam logic [CW-1:0] HI10 = CW'(win_hi(CW, 10));
  localparam logic [CW-1:0] LO12 = CW'(win_lo(CW, 12));
  localparam logic [CW-1:0] HI12 = CW'(win_hi(CW, 12));

  logic          use_prog;
  logic [CW-1:0] fix_lo, fix_hi;

  always_comb begin
    act_o    = en_i;
    use_prog = 1'b0;
    fix_lo   = '0;
    fix_hi   = '1;
    case (fmt_i)
      FMT_LIM8:  begin fix_lo = LO8;  fix_hi = HI8;  end
      FMT_LIM10: begin fix_lo = LO10; fix_hi = HI10; end
      FMT_LIM12: begin fix_lo = LO12; fix_hi = HI12; end
      FMT_PROG:  use_prog = 1'b1;
      default:   act_o = 1'b0;  // full range and undefined codes
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign lo_o[c*CW +: CW] = use_prog ? prog_lo_i[c*CW +: CW] : fix_lo;
    assign hi_o[c*CW +: CW] = use_prog ? prog_hi_i[c*CW +: CW] : fix_hi;
  end

endmodule

// File: rtl/clamp_limit.sv
module clamp_limit #(
  parameter int unsigned CW = 12
) (
  input  logic          act_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic [CW-1:0] y_o
);

  // lower test has priority over upper when bounds cross
  always_comb begin
    if (!act_i)         y_o = x_i;
    else if (x_i < lo_i) y_o = lo_i;
    else if (x_i > hi_i) y_o = hi_i;
    else                 y_o = x_i;
  end

endmodule

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int unsigned   CW     = 12,
  parameter int unsigned   NCH    = 3,
  parameter logic [CW-1:0] LO_RST = 'h010,
  parameter logic [CW-1:0] HI_RST = 'hFEF,
  localparam int unsigned  PW     = CW * NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [2:0]    fmt_i,
  input  logic          bnd_ld_i,
  input  logic [PW-1:0] lo_i,
  input  logic [PW-1:0] hi_i,
  input  logic [PW-1:0] pix_i,
  input  logic          vld_i,
  output logic [PW-1:0] pix_o,
  output logic          vld_o
);

  logic [PW-1:0] prog_lo, prog_hi, act_lo, act_hi, pix_d;
  logic          act;

  clamp_bounds #(.CW(CW), .NCH(NCH), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_bounds (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (bnd_ld_i),
    .lo_i   (lo_i),
    .hi_i   (hi_i),
    .lo_q_o (prog_lo),
    .hi_q_o (prog_hi)
  );

  clamp_window_sel #(.CW(CW), .NCH(NCH)) u_sel (
    .en_i      (en_i),
    .fmt_i     (fmt_i),
    .prog_lo_i (prog_lo),
    .prog_hi_i (prog_hi),
    .act_o     (act),
    .lo_o      (act_lo),
    .hi_o      (act_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lim
    clamp_limit #(.CW(CW)) u_lim (
      .act_i (act),
      .x_i   (pix_i[c*CW +: CW]),
      .lo_i  (act_lo[c*CW +: CW]),
      .hi_i  (act_hi[c*CW +: CW]),
      .y_o   (pix_d[c*CW +: CW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) pix_o <= pix_d;
    end
  end

endmodule

// File: rtl/range_clamp_chk.sv
module range_clamp_chk #(
  parameter int unsigned  CW  = 12,
  parameter int unsigned  NCH = 3,
  localparam int unsigned PW  = CW * NCH
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [2:0]    fmt_i,
  input logic [PW-1:0] pix_i,
  input logic          vld_i,
  input logic [PW-1:0] pix_o,
  input logic          vld_o
);

  localparam logic [CW-1:0] FLO = CW'(range_clamp_pkg::win_lo(CW, 12));
  localparam logic [CW-1:0] FHI = CW'(range_clamp_pkg::win_hi(CW, 12));

  a_r8_vld_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r8_vld_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pix_o));
  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !en_i) |=> pix_o == $past(pix_i));
  a_r3_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (fmt_i == 3'd0 || fmt_i == 3'd4 || fmt_i == 3'd5 || fmt_i == 3'd6))
      |=> pix_o == $past(pix_i));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && en_i && fmt_i >= 3'd1 && fmt_i <= 3'd3)
        |=> (pix_o[c*CW +: CW] >= FLO && pix_o[c*CW +: CW] <= FHI));
  end

endmodule

bind range_clamp range_clamp_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .fmt_i  (fmt_i),
  .pix_i  (pix_i),
  .vld_i  (vld_i),
  .pix_o  (pix_o),
  .vld_o  (vld_o)
);

// File: tb/range_clamp_tb_top.sv
module range_clamp_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        ld = 1'b0;
  logic [35:0] lo = '0, hi = '0, pix = '0;
  logic        vld = 1'b0;
  logic [35:0] pix_o;
  logic        vld_o;

  int checks = 0, fails = 0;
  logic [11:0] m_lo [3];
  logic [11:0] m_hi [3];
  logic [35:0] exp_hold = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_clamp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fmt_i(fmt), .bnd_ld_i(ld),
    .lo_i(lo), .hi_i(hi), .pix_i(pix), .vld_i(vld), .pix_o(pix_o), .vld_o(vld_o)
  );

  function automatic logic [35:0] model(logic e, logic [2:0] f, logic [35:0] p);
    logic [35:0] r;
    for (int c = 0; c < 3; c++) begin
      logic [11:0] x, l, h, y;
      logic act;
      x = p[c*12 +: 12];
      act = e;
      l = 12'h000; h = 12'hFFF;
      if (f >= 3'd1 && f <= 3'd3) begin l = 12'h100; h = 12'hEB0; end
      else if (f == 3'd7) begin l = m_lo[c]; h = m_hi[c]; end
      else act = 1'b0;
      if (!act) y = x;
      else if (x < l) y = l;
      else if (x > h) y = h;
      else y = x;
      r[c*12 +: 12] = y;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string auto_tag(logic e, logic [2:0] f);
    if (!e) return "R2";
    if (f >= 3'd1 && f <= 3'd3) return "R4";
    if (f == 3'd7) return "R5";
    return "R3";
  endfunction

  task automatic step(string tag, logic e, logic [2:0] f, logic l, logic [35:0] lv,
                      logic [35:0] hv, logic [35:0] p, logic v);
    logic [35:0] ex;
    string t;
    en = e; fmt = f; ld = l; lo = lv; hi = hv; pix = p; vld = v;
    t = (tag == "") ? auto_tag(e, f) : tag;
    ex = v ? model(e, f, p) : exp_hold;
    @(posedge clk);
    if (l) for (int c = 0; c < 3; c++) begin
      m_lo[c] = lv[c*12 +: 12];
      m_hi[c] = hv[c*12 +: 12];
    end
    exp_hold = ex;
    @(negedge clk);
    chk({t, " vld"}, {35'd0, vld_o}, {35'd0, v});
    chk({t, " pix"}, pix_o, ex);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 3; c++) begin m_lo[c] = 12'h010; m_hi[c] = 12'hFEF; end
    repeat (3) @(negedge clk);
    chk("R1 rst vld", {35'd0, vld_o}, 36'd0);
    chk("R1 rst pix", pix_o, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post vld", {35'd0, vld_o}, 36'd0);
    chk("R1 post pix", pix_o, 36'd0);

    // R5 reset-default programmable window
    step("R5", 1, 3'd7, 0, '0, '0, {12'h000, 12'h010, 12'hFFF}, 1);
    step("R5", 1, 3'd7, 0, '0, '0, {12'hFEF, 12'hFF0, 12'h00F}, 1);
    // R4 fixed windows
    step("R4", 1, 3'd1, 0, '0, '0, {12'h000, 12'h100, 12'hFFF}, 1);
    step("R4", 1, 3'd2, 0, '0, '0, {12'h0FF, 12'hEB0, 12'hEB1}, 1);
    step("R4", 1, 3'd3, 0, '0, '0, {12'h7FF, 12'h001, 12'hFFE}, 1);
    // R3 full range and undefined codes
    for (int f = 4; f <= 6; f++)
      step("R3", 1, 3'(f), 0, '0, '0, {12'h000, 12'hFFF, 12'h005}, 1);
    step("R3", 1, 3'd0, 0, '0, '0, {12'hFFF, 12'h000, 12'hEB1}, 1);
    // R2 disabled
    step("R2", 0, 3'd7, 0, '0, '0, {12'h000, 12'hFFF, 12'h001}, 1);
    step("R2", 0, 3'd1, 0, '0, '0, {12'hFFF, 12'h000, 12'hFF0}, 1);
    // R6 load takes effect after its own edge; R9 distinct per-channel bounds
    step("R6", 1, 3'd7, 1, {12'h100, 12'h200, 12'h300}, {12'h800, 12'h900, 12'hA00},
         {12'h000, 12'h000, 12'hFFF}, 1);
    step("R6", 1, 3'd7, 0, '0, '0, {12'h000, 12'h000, 12'hFFF}, 1);
    step("R9", 1, 3'd7, 0, '0, '0, {12'hFFF, 12'h250, 12'h000}, 1);
    // R7 inside window unchanged, crossed bounds lower-first
    step("R7", 1, 3'd7, 0, '0, '0, {12'h400, 12'h500, 12'h600}, 1);
    step("R7", 1, 3'd7, 1, {3{12'h800}}, {3{12'h400}}, {12'h100, 12'h600, 12'h900}, 1);
    step("R7", 1, 3'd7, 0, '0, '0, {12'h100, 12'h600, 12'h900}, 1);
    // R8 hold while invalid
    step("R8", 1, 3'd0, 0, '0, '0, {12'h123, 12'h456, 12'h789}, 0);
    step("R8", 0, 3'd3, 0, '0, '0, {12'hFFF, 12'hFFF, 12'hFFF}, 0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] f;
      logic [35:0] p, lv, hv;
      f  = 3'($urandom % 8);
      if ($urandom % 3 == 0) f = 3'd7;
      p  = {12'($urandom), 12'($urandom), 12'($urandom)};
      lv = {12'($urandom % 2048), 12'($urandom % 2048), 12'($urandom % 2048)};
      hv = {12'(2048 + $urandom % 2048), 12'(2048 + $urandom % 2048), 12'(2048 + $urandom % 2048)};
      step("", ($urandom % 8) != 0, f, ($urandom % 10) == 0, lv, hv, p, ($urandom % 5) != 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule